// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the central control unit of a six-stage in-order pipeline whose stages are, in order, fetch (IF, stage 0), decode (ID, stage 1), register read (RR, stage 2), execute (EX, stage 3), memory (MM, stage 4) and write-back (WB, stage 5). Each cycle it gathers five hazard sources:

- a privileged-call flush and a data-cache stall, both supplied from outside;
- a branch misprediction, a multi-cycle execute stall and a load-use dependency stall, all three derived inside the block.

It picks the single winner by fixed priority and turns it into one advance control and one kill control per stage. The pipeline registers use these to load, clear or hold their contents.

The block also owns the fetch PC register and computes its next value from the redirects, the stall state and the branch predictor's guess. Two event counters track retired instructions and mispredict flushes. The pipeline registers, operand forwarding and the datapath sit around this block and are not part of it.

Top module: `hzc_pipe_ctrl`

## Requirements
- R1: While reset is low, `fetch_pc` equals the `RESET_PC` parameter and both `misp_count` and `retire_count` read zero.
- R2: When several hazards are present in the same cycle, exactly one is acted on. The order from strongest to weakest is: privileged flush (`priv_flush`), data-cache stall (`dcache_stall`), mispredict, latency stall, dependency stall.
- R3: Each stage i uses bit i of `stg_adv` and `stg_kill`. Writing bits in IF..WB order (left character = IF), the controls for the winning hazard are:

  | Winning hazard | `stg_adv` | `stg_kill` |
  |---|---|---|
  | none | 111111 | 000000 |
  | privileged | 111111 | 000000 |
  | data-cache | 000011 | 000000 |
  | mispredict | 111111 | 000000 |
  | latency | 000111 | 100000 |
  | dependency | 001111 | 100000 |

  Underneath, each hazard sets a bubble mask and an update mask, in the same IF..WB order: privileged 111110/111111, data-cache 000010/000011, mispredict 111000/111111, latency 100100/000111, dependency 101000/001111. A stage advances where its update bit is set. It is killed only where its bubble bit is set without its update bit. Otherwise it holds.
- R4: `dep_stall` is 1 when RR and EX are both valid, EX holds a load (`ex_is_load`), and the load's destination `ex_dst` equals `rr_src_a` or `rr_src_b`.
- R5: A 6-bit register id is {file bit, 5-bit number}. The file bit takes part in the compare. When `rr_is_cmov` is 1, a match of `rr_src_m` against `ex_dst` also raises `dep_stall`. A destination whose number is 31, in either file, never matches anything.
- R6: `ex_opc` gives the execute latency: 1 is an integer multiply taking `MUL_LAT` cycles, 2 is a float operation taking `FLT_LAT` cycles, and 0 or 3 take one cycle. While valid in EX, an operation of latency L raises `lat_stall` for its first L-1 cycles, then drops it in its final cycle.
- R7: The latency countdown does not advance during a cycle with `dcache_stall` set. A privileged flush resets it, so the operation then found in EX starts a fresh count.
- R8: A mispredict (`misp_flush`) is raised only in an EX operation's final cycle, when `ex_resolved_pc` differs from `ex_pred_pc`. It is never raised while `lat_stall` is 1.
- R9: The next `fetch_pc` is chosen by the first case that applies:
  1. `priv_pc` on a privileged flush;
  2. `ex_resolved_pc` on a mispredict flush;
  3. the current value when any of `icache_stall`, `dcache_stall`, `lat_stall` or `dep_stall` is set;
  4. `pred_target` when `pred_taken` is set;
  5. otherwise the current value plus 4.
- R10: `misp_count` rises by one in the cycle after each mispredict flush.
- R11: `retire_count` rises by one in the cycle after each cycle in which WB is valid (`stg_valid[5]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_valid | input | 6 | Valid flag per stage, bit i = stage i (IF=0 .. WB=5) |
| rr_src_a | input | 6 | RR source A register id |
| rr_src_b | input | 6 | RR source B register id |
| rr_src_m | input | 6 | RR conditional-move extra source id |
| rr_is_cmov | input | 1 | RR instruction is a conditional move |
| ex_dst | input | 6 | EX destination register id |
| ex_is_load | input | 1 | EX instruction is a load |
| ex_opc | input | 2 | EX latency class (0 single, 1 multiply, 2 float, 3 single) |
| ex_pred_pc | input | PC_W | Predicted next PC of the EX instruction |
| ex_resolved_pc | input | PC_W | Resolved next PC of the EX instruction |
| icache_stall | input | 1 | Instruction cache waiting for a line |
| dcache_stall | input | 1 | Data cache waiting for a line |
| priv_flush | input | 1 | Privileged call retiring in WB, flush requested |
| priv_pc | input | PC_W | Redirect address for the privileged flush |
| pred_taken | input | 1 | Predictor says the fetched instruction is taken |
| pred_target | input | PC_W | Predicted target address |
| stg_adv | output | 6 | Per-stage advance (load from previous stage) |
| stg_kill | output | 6 | Per-stage bubble insertion |
| fetch_pc | output | PC_W | Current fetch PC |
| dep_stall | output | 1 | Load-use dependency detected |
| lat_stall | output | 1 | Multi-cycle execute still busy |
| misp_flush | output | 1 | Mispredict flush acted on this cycle |
| misp_count | output | CNT_W | Mispredict flush count |
| retire_count | output | CNT_W | Retired instruction count |

## Verification
The bench builds the block with `PC_W` = 16, `CNT_W` = 16, `RESET_PC` = 16'h0100, and the default latencies of 4 and 5. The narrow PC and counters keep every expected value small enough to track cycle by cycle.

With this setup the bench can sweep:

- every pairing of a five-value register-id set, including number 31 in both files and ids that differ only in the file bit, across sources A, B and M, with the load and conditional-move flags on and off;
- all reachable combinations of the five hazard sources, checking the priority order.

The latency counts are short enough to follow each multi-cycle operation through freezes, privileged resets and late mispredicts.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int unsigned NSTG  = 6;
  localparam int unsigned RID_W = 6;
  localparam logic [4:0]  NULL_REG = 5'd31;

  typedef logic [RID_W-1:0] rid_t;
  typedef logic [NSTG-1:0]  smask_t;

  typedef enum logic [2:0] {
    HZ_NONE  = 3'd0,
    HZ_PRIV  = 3'd1,
    HZ_DMISS = 3'd2,
    HZ_MISP  = 3'd3,
    HZ_LAT   = 3'd4,
    HZ_DEP   = 3'd5
  } hz_src_e;

  typedef enum logic [1:0] {
    OPC_PLAIN = 2'd0,
    OPC_IMUL  = 2'd1,
    OPC_FLT   = 2'd2,
    OPC_MISC  = 2'd3
  } opc_e;

  // a destination numbered 31 is a discard target and never produces a hazard
  function automatic logic rid_live(rid_t r);
    return r[4:0] != NULL_REG;
  endfunction

  function automatic logic rid_hit(rid_t src, rid_t dst);
    return rid_live(dst) && (src == dst);
  endfunction

  function automatic int unsigned op_cycles(opc_e c, int unsigned mul_c, int unsigned flt_c);
    case (c)
      OPC_IMUL: return mul_c;
      OPC_FLT:  return flt_c;
      default:  return 1;
    endcase
  endfunction

  // bit i = stage i (IF=0 .. WB=5)
  function automatic smask_t bubble_mask(hz_src_e h);
    case (h)
      HZ_PRIV:  return 6'b011111;
      HZ_DMISS: return 6'b010000;
      HZ_MISP:  return 6'b000111;
      HZ_LAT:   return 6'b001001;
      HZ_DEP:   return 6'b000101;
      default:  return 6'b000000;
    endcase
  endfunction

  function automatic smask_t update_mask(hz_src_e h);
    case (h)
      HZ_DMISS: return 6'b110000;
      HZ_LAT:   return 6'b111000;
      HZ_DEP:   return 6'b111100;
      default:  return 6'b111111;
    endcase
  endfunction
endpackage

// File: rtl/hzc_dep_check.sv
module hzc_dep_check
  import hzc_pkg::*;
(
  input  logic rr_valid,
  input  logic ex_valid,
  input  logic ex_is_load,
  input  rid_t src_a,
  input  rid_t src_b,
  input  rid_t src_m,
  input  logic rr_is_cmov,
  input  rid_t ex_dst,
  output logic dep_stall
);
  localparam int unsigned NSRC = 3;

  logic [NSRC-1:0][RID_W-1:0] srcs;
  logic [NSRC-1:0]            use_src;
  logic [NSRC-1:0]            hit;

  assign srcs    = {src_m, src_b, src_a};
  assign use_src = {rr_is_cmov, 1'b1, 1'b1};

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = use_src[k] && rid_hit(srcs[k], ex_dst);
  end

  assign dep_stall = rr_valid && ex_valid && ex_is_load && (|hit);
endmodule

// File: rtl/hzc_lat_timer.sv
module hzc_lat_timer
  import hzc_pkg::*;
#(
  parameter int unsigned MUL_LAT = 4,
  parameter int unsigned FLT_LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_valid,
  input  opc_e ex_opc,
  input  logic freeze,
  input  logic clear,
  output logic lat_stall,
  output logic ex_done
);
  localparam int unsigned LMAX  = (MUL_LAT > FLT_LAT) ? MUL_LAT : FLT_LAT;
  localparam int unsigned LAT_W = $clog2(LMAX + 1);

  logic [LAT_W-1:0] remain;
  logic [LAT_W-1:0] lat_now;
  logic             idle;

  assign lat_now   = LAT_W'(op_cycles(ex_opc, MUL_LAT, FLT_LAT));
  assign idle      = (remain == '0);
  assign ex_done   = ex_valid && ((remain == LAT_W'(1)) || (idle && lat_now <= LAT_W'(1)));
  assign lat_stall = ex_valid && !ex_done;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      remain <= '0;
    end else if (!freeze) begin
      if (idle) begin
        if (ex_valid && lat_now > LAT_W'(1)) remain <= lat_now - LAT_W'(1);
      end else begin
        remain <= remain - LAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hzc_pc_sel.sv
module hzc_pc_sel #(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_flush,
  input  logic [PC_W-1:0] priv_pc,
  input  logic            misp_flush,
  input  logic [PC_W-1:0] misp_pc,
  input  logic            hold,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] pred_target,
  output logic [PC_W-1:0] fetch_pc
);
  function automatic logic [PC_W-1:0] pick_next(
    logic pf, logic [PC_W-1:0] ppc, logic mf, logic [PC_W-1:0] mpc,
    logic hd, logic pt, logic [PC_W-1:0] tgt, logic [PC_W-1:0] cur);
    if (pf)      return ppc;
    else if (mf) return mpc;
    else if (hd) return cur;
    else if (pt) return tgt;
    else         return cur + PC_W'(4);
  endfunction

  logic [PC_W-1:0] pc_nxt;

  assign pc_nxt = pick_next(priv_flush, priv_pc, misp_flush, misp_pc,
                            hold, pred_taken, pred_target, fetch_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_pc <= RESET_PC;
    else        fetch_pc <= pc_nxt;
  end
endmodule

// File: rtl/hzc_evt_ctr.sv
module hzc_evt_ctr #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] count
);
  for (genvar k = 0; k < N; k++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)      count[k] <= '0;
      else if (inc[k]) count[k] <= count[k] + W'(1);
    end
  end
endmodule

// File: rtl/hzc_pipe_ctrl.sv
module hzc_pipe_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h0000_1000),
  parameter int unsigned     MUL_LAT  = 4,
  parameter int unsigned     FLT_LAT  = 5,
  parameter int unsigned     CNT_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       stg_valid,
  input  logic [5:0]       rr_src_a,
  input  logic [5:0]       rr_src_b,
  input  logic [5:0]       rr_src_m,
  input  logic             rr_is_cmov,
  input  logic [5:0]       ex_dst,
  input  logic             ex_is_load,
  input  logic [1:0]       ex_opc,
  input  logic [PC_W-1:0]  ex_pred_pc,
  input  logic [PC_W-1:0]  ex_resolved_pc,
  input  logic             icache_stall,
  input  logic             dcache_stall,
  input  logic             priv_flush,
  input  logic [PC_W-1:0]  priv_pc,
  input  logic             pred_taken,
  input  logic [PC_W-1:0]  pred_target,
  output logic [5:0]       stg_adv,
  output logic [5:0]       stg_kill,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             dep_stall,
  output logic             lat_stall,
  output logic             misp_flush,
  output logic [CNT_W-1:0] misp_count,
  output logic [CNT_W-1:0] retire_count
);
  localparam int unsigned ST_RR = 2;
  localparam int unsigned ST_EX = 3;
  localparam int unsigned ST_WB = NSTG - 1;
  localparam int unsigned C_RET = 0;
  localparam int unsigned C_MSP = 1;

  hz_src_e                hz;
  smask_t                 bub, upd;
  logic                   ex_done;
  logic                   misp_raw;
  logic                   any_hold;
  logic [1:0]             ctr_inc;
  logic [1:0][CNT_W-1:0]  ctr_val;

  hzc_dep_check u_dep (
    .rr_valid   (stg_valid[ST_RR]),
    .ex_valid   (stg_valid[ST_EX]),
    .ex_is_load (ex_is_load),
    .src_a      (rr_src_a),
    .src_b      (rr_src_b),
    .src_m      (rr_src_m),
    .rr_is_cmov (rr_is_cmov),
    .ex_dst     (ex_dst),
    .dep_stall  (dep_stall)
  );

  hzc_lat_timer #(.MUL_LAT(MUL_LAT), .FLT_LAT(FLT_LAT)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (stg_valid[ST_EX]),
    .ex_opc    (opc_e'(ex_opc)),
    .freeze    (dcache_stall),
    .clear     (priv_flush),
    .lat_stall (lat_stall),
    .ex_done   (ex_done)
  );

  assign misp_raw = ex_done && (ex_resolved_pc != ex_pred_pc);

  always_comb begin
    if      (priv_flush)   hz = HZ_PRIV;
    else if (dcache_stall) hz = HZ_DMISS;
    else if (misp_raw)     hz = HZ_MISP;
    else if (lat_stall)    hz = HZ_LAT;
    else if (dep_stall)    hz = HZ_DEP;
    else                   hz = HZ_NONE;
  end

  assign bub        = bubble_mask(hz);
  assign upd        = update_mask(hz);
  assign stg_adv    = upd;
  assign stg_kill   = bub & ~upd;
  assign misp_flush = (hz == HZ_MISP);
  assign any_hold   = icache_stall | dcache_stall | lat_stall | dep_stall;

  hzc_pc_sel #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_flush  (priv_flush),
    .priv_pc     (priv_pc),
    .misp_flush  (misp_flush),
    .misp_pc     (ex_resolved_pc),
    .hold        (any_hold),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .fetch_pc    (fetch_pc)
  );

  assign ctr_inc[C_RET] = stg_valid[ST_WB];
  assign ctr_inc[C_MSP] = misp_flush;

  hzc_evt_ctr #(.W(CNT_W), .N(2)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ctr_inc),
    .count (ctr_val)
  );

  assign retire_count = ctr_val[C_RET];
  assign misp_count   = ctr_val[C_MSP];
endmodule

// File: rtl/hzc_pipe_ctrl_chk.sv
module hzc_pipe_ctrl_chk
  import hzc_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       stg_valid,
  input logic             ex_is_load,
  input logic             icache_stall,
  input logic             dcache_stall,
  input logic             priv_flush,
  input logic [PC_W-1:0]  priv_pc,
  input logic [5:0]       stg_adv,
  input logic [5:0]       stg_kill,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             dep_stall,
  input logic             lat_stall,
  input logic             misp_flush,
  input logic             ex_done,
  input logic [CNT_W-1:0] misp_count,
  input logic [CNT_W-1:0] retire_count
);
  AST_PRIV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    priv_flush |-> (stg_adv == 6'h3F && stg_kill == 6'h00)); // R2
  AST_DMISS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dcache_stall && !priv_flush) |-> (stg_adv == 6'h30 && stg_kill == 6'h00)); // R3
  AST_DEP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !dep_stall); // R4
  AST_MISP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    misp_flush |-> (ex_done && !lat_stall)); // R8
  AST_PC_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    priv_flush |=> fetch_pc == $past(priv_pc)); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (icache_stall && !priv_flush && !misp_flush) |=> fetch_pc == $past(fetch_pc)); // R9
  AST_MISP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    misp_flush |=> misp_count == $past(misp_count) + CNT_W'(1)); // R10
  AST_RET_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid[5] |=> retire_count == $past(retire_count) + CNT_W'(1)); // R11
endmodule

bind hzc_pipe_ctrl hzc_pipe_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stg_valid    (stg_valid),
  .ex_is_load   (ex_is_load),
  .icache_stall (icache_stall),
  .dcache_stall (dcache_stall),
  .priv_flush   (priv_flush),
  .priv_pc      (priv_pc),
  .stg_adv      (stg_adv),
  .stg_kill     (stg_kill),
  .fetch_pc     (fetch_pc),
  .dep_stall    (dep_stall),
  .lat_stall    (lat_stall),
  .misp_flush   (misp_flush),
  .ex_done      (ex_done),
  .misp_count   (misp_count),
  .retire_count (retire_count)
);

// File: tb/hzc_pipe_ctrl_tb.sv
module hzc_pipe_ctrl_tb_top;
  localparam int unsigned PC_W = 16;
  localparam int unsigned CW   = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [5:0]      stg_valid;
  logic [5:0]      rr_src_a, rr_src_b, rr_src_m, ex_dst;
  logic            rr_is_cmov, ex_is_load;
  logic [1:0]      ex_opc;
  logic [15:0]     ex_pred_pc, ex_resolved_pc, priv_pc, pred_target;
  logic            icache_stall, dcache_stall, priv_flush, pred_taken;
  logic [5:0]      stg_adv, stg_kill;
  logic [15:0]     fetch_pc;
  logic            dep_stall, lat_stall, misp_flush;
  logic [15:0]     misp_count, retire_count;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_pc;
  logic [15:0] exp_misp;
  logic [15:0] exp_ret;

  always #5 clk = ~clk;

  hzc_pipe_ctrl #(.PC_W(PC_W), .RESET_PC(16'h0100), .MUL_LAT(4), .FLT_LAT(5), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid),
    .rr_src_a(rr_src_a), .rr_src_b(rr_src_b), .rr_src_m(rr_src_m), .rr_is_cmov(rr_is_cmov),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_opc(ex_opc),
    .ex_pred_pc(ex_pred_pc), .ex_resolved_pc(ex_resolved_pc),
    .icache_stall(icache_stall), .dcache_stall(dcache_stall),
    .priv_flush(priv_flush), .priv_pc(priv_pc),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .stg_adv(stg_adv), .stg_kill(stg_kill), .fetch_pc(fetch_pc),
    .dep_stall(dep_stall), .lat_stall(lat_stall), .misp_flush(misp_flush),
    .misp_count(misp_count), .retire_count(retire_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // masks written stage IF first (left) to WB (right), flipped to bit i = stage i
  function automatic logic [5:0] flip(input logic [5:0] s);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = s[5-i];
    return r;
  endfunction

  // hazard codes: 0 none, 1 privileged, 2 data-cache, 3 mispredict, 4 latency, 5 dependency
  function automatic logic [5:0] e_bub(input int h);
    case (h)
      1: return flip(6'b111110);
      2: return flip(6'b000010);
      3: return flip(6'b111000);
      4: return flip(6'b100100);
      5: return flip(6'b101000);
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] e_upd(input int h);
    case (h)
      2: return flip(6'b000011);
      4: return flip(6'b000111);
      5: return flip(6'b001111);
      default: return flip(6'b111111);
    endcase
  endfunction

  task automatic idle_in();
    stg_valid = 6'b0; rr_src_a = 6'h00; rr_src_b = 6'h00; rr_src_m = 6'h00;
    rr_is_cmov = 1'b0; ex_dst = 6'h00; ex_is_load = 1'b0; ex_opc = 2'd0;
    ex_pred_pc = 16'h0200; ex_resolved_pc = 16'h0200;
    icache_stall = 1'b0; dcache_stall = 1'b0; priv_flush = 1'b0; priv_pc = 16'h0040;
    pred_taken = 1'b0; pred_target = 16'h0400;
  endtask

  // called just after a falling edge with the inputs already set
  task automatic cycle(input string req, input int h, input bit elat, input bit edep);
    logic [5:0]  eb, eu;
    logic [15:0] npc;
    #1;
    eb = e_bub(h);
    eu = e_upd(h);
    chk({req, " adv"}, stg_adv, eu);
    chk({req, " kill"}, stg_kill, eb & ~eu);
    chk("R8 misp_flush", misp_flush, (h == 3));
    chk("R6 lat_stall", lat_stall, elat);
    chk("R4 dep_stall", dep_stall, edep);
    if (priv_flush)                                   npc = priv_pc;
    else if (h == 3)                                  npc = ex_resolved_pc;
    else if (elat || edep || icache_stall || dcache_stall) npc = exp_pc;
    else if (pred_taken)                              npc = pred_target;
    else                                              npc = exp_pc + 16'd4;
    if (h == 3) exp_misp = exp_misp + 16'd1;
    if (stg_valid[5]) exp_ret = exp_ret + 16'd1;
    @(negedge clk);
    chk("R9 fetch_pc", fetch_pc, npc);
    chk("R10 misp_count", misp_count, exp_misp);
    chk("R11 retire_count", retire_count, exp_ret);
    exp_pc = npc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired total=%0d", total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] vals [5];
    vals[0] = 6'h05; vals[1] = 6'h25; vals[2] = 6'h1F; vals[3] = 6'h3F; vals[4] = 6'h00;
    idle_in();
    rst_n = 1'b0;
    stg_valid = 6'b100000;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", fetch_pc, 16'h0100);
    chk("R1 reset misp", misp_count, 16'h0);
    chk("R1 reset ret", retire_count, 16'h0);
    rst_n = 1'b1;
    exp_pc = 16'h0100; exp_misp = '0; exp_ret = '0;
    idle_in();

    // free run with retirements: R3 none, R11
    for (int i = 0; i < 4; i++) begin
      stg_valid = (i % 2 == 0) ? 6'b100000 : 6'b000000;
      cycle("R3 none", 0, 0, 0);
    end
    // predicted taken, then icache hold: R9
    pred_taken = 1'b1; cycle("R9 taken", 0, 0, 0);
    icache_stall = 1'b1; cycle("R9 ic hold", 0, 0, 0);
    idle_in();

    // dependency sweep: R4 R5
    for (int ld = 0; ld < 2; ld++)
      for (int d = 0; d < 5; d++)
        for (int a = 0; a < 5; a++)
          for (int b = 0; b < 5; b++)
            for (int m = 0; m < 5; m++)
              for (int c = 0; c < 2; c++) begin
                bit e;
                stg_valid = 6'b001100; ex_is_load = ld[0]; ex_dst = vals[d];
                rr_src_a = vals[a]; rr_src_b = vals[b]; rr_src_m = vals[m]; rr_is_cmov = c[0];
                e = ld[0] && (vals[d][4:0] != 5'd31) &&
                    (vals[a] == vals[d] || vals[b] == vals[d] || (c[0] && vals[m] == vals[d]));
                cycle(e ? "R5 dep" : "R5 nodep", e ? 5 : 0, 0, e);
              end
    // RR empty: no dependency (R4)
    stg_valid = 6'b001000; ex_is_load = 1'b1; ex_dst = 6'h05; rr_src_a = 6'h05;
    cycle("R4 rr empty", 0, 0, 0);
    idle_in();

    // latency per class: R6
    for (int oc = 0; oc < 4; oc++) begin
      int lat;
      lat = (oc == 1) ? 4 : (oc == 2) ? 5 : 1;
      stg_valid = 6'b001000; ex_opc = oc[1:0];
      for (int k = 0; k < lat; k++) begin
        bit s;
        s = (k < lat - 1);
        cycle(s ? "R6 lat" : "R6 done", s ? 4 : 0, s, 0);
      end
      idle_in();
      cycle("R6 gap", 0, 0, 0);
    end

    // freeze under data-cache stall: R7
    stg_valid = 6'b001000; ex_opc = 2'd1;
    cycle("R7 lat", 4, 1, 0);
    dcache_stall = 1'b1; cycle("R7 dmiss", 2, 1, 0);
    dcache_stall = 1'b0;
    cycle("R7 lat", 4, 1, 0);
    cycle("R7 lat", 4, 1, 0);
    cycle("R7 done", 0, 0, 0);
    idle_in(); cycle("R7 gap", 0, 0, 0);

    // privileged flush restarts the count: R7
    stg_valid = 6'b001000; ex_opc = 2'd1;
    cycle("R7 lat", 4, 1, 0);
    priv_flush = 1'b1; priv_pc = 16'h0044; cycle("R7 priv", 1, 1, 0);
    priv_flush = 1'b0;
    cycle("R7 refire", 4, 1, 0);
    cycle("R7 lat", 4, 1, 0);
    cycle("R7 lat", 4, 1, 0);
    cycle("R7 done", 0, 0, 0);
    idle_in(); cycle("R7 gap", 0, 0, 0);

    // single-cycle mispredict, then late mispredict of a multiply: R8
    stg_valid = 6'b001000; ex_resolved_pc = 16'h0300;
    cycle("R8 misp", 3, 0, 0);
    ex_opc = 2'd1; ex_resolved_pc = 16'h0308;
    cycle("R8 wait", 4, 1, 0);
    cycle("R8 wait", 4, 1, 0);
    cycle("R8 wait", 4, 1, 0);
    cycle("R8 late misp", 3, 0, 0);
    idle_in(); cycle("R8 gap", 0, 0, 0);

    // priority sweep over privileged, data-cache, mispredict, latency, dependency: R2
    for (int v = 0; v < 32; v++) begin
      bit p, dc, mp, lt, dp;
      int h;
      p = v[0]; dc = v[1]; mp = v[2]; lt = v[3]; dp = v[4];
      if (!(mp && lt)) begin
        stg_valid = 6'b101100; pred_taken = 1'b1; pred_target = 16'h0800;
        priv_flush = p; priv_pc = 16'h0050; dcache_stall = dc;
        ex_opc = lt ? 2'd1 : 2'd0;
        ex_resolved_pc = mp ? 16'h0600 : ex_pred_pc;
        ex_is_load = dp; ex_dst = 6'h07; rr_src_a = dp ? 6'h07 : 6'h02;
        h = p ? 1 : dc ? 2 : mp ? 3 : lt ? 4 : dp ? 5 : 0;
        cycle("R2 prio", h, lt, dp);
        idle_in();
        for (int k = 0; k < 4; k++) cycle("R2 drain", 0, 0, 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule